// File: doc/BRIEF.md
# Page permission checker

This block decides whether a single memory access may proceed once a translation walk has reached its final descriptor, and what rights the resulting TLB entry should carry. It takes the leaf descriptor, a 5-bit set of restriction flags gathered from the table descriptors passed on the way down, the current privilege level (kernel or user) and the kind of access. It answers with a protection-fault flag for this access and a read/write/execute mask for the TLB. Both answers are purely combinational.

The block also holds the small decoder that a walker applies at every table level. It turns one table descriptor's attribute field into restriction flags and ORs them into the running set. The walker keeps that set in a register and feeds it back in as `acc_flags_i`. Fetching descriptors, recognising leaf versus table entries, and sequencing faults are all left to the walker.

Top module: `leaf_access_guard`

## Requirements
- R1: `acc_flags_o` equals `acc_flags_i` ORed with flags decoded from table descriptor bits 63:59, where field bit k is descriptor bit 59+k. Field bit 0 sets flag 0 (kernel execute-never). Field bit 1 sets flag 1 (user execute-never). Field bits 3:2 select a limit: code 1 sets flag 4 (no user mode), code 2 sets flag 3 (no write), code 3 sets flag 2 (no user read/write), and code 0 sets nothing. Field bit 4 is ignored.
- R2: The access kind is encoded read=0, write=1, fetch=2, inspect=3. A write to a leaf with bit 7 set (read-only) raises `fault_o` in both kernel and user mode.
- R3: In kernel mode (`user_mode_i`=0), a fetch raises `fault_o` when leaf bit 53 (kernel execute-never) or flag 0 is set.
- R4: In user mode, every access kind, inspect included, raises `fault_o` when flag 4 is set or leaf bit 6 is clear (kernel-only page).
- R5: In user mode, a read or write raises `fault_o` when flag 2 is set. A fetch raises `fault_o` when leaf bit 54 (user execute-never) or flag 1 is set.
- R6: An inspect access faults only under the conditions of R4. It never faults for read-only, execute-never or user read/write limits.
- R7: `perm_o` uses bit 0 for read, bit 1 for write and bit 2 for execute. It starts from all three allowed. Write is removed when flag 3 or leaf bit 7 is set, in either mode.
- R8: Execute is removed in kernel mode by flag 0 or leaf bit 53, and in user mode by flag 1 or leaf bit 54.
- R9: In user mode, flag 4 or a clear leaf bit 6 removes all three rights, and flag 2 removes read and write.
- R10: Flag 3 alone never raises `fault_o`. `perm_o` does not depend on the access kind. In kernel mode, flags 1, 2, 4 and leaf bits 6 and 54 have no effect on either output. Leaf bits other than 6, 7, 53 and 54, and table bits outside 63:59, have no effect.
- R11: All outputs follow their inputs within the same cycle, with no clock or state involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tbl_desc_i | input | 64 | Table descriptor being passed during a walk |
| acc_flags_i | input | 5 | Restriction flags accumulated so far |
| acc_flags_o | output | 5 | Accumulated flags merged with this table's flags |
| leaf_desc_i | input | 64 | Final leaf descriptor of the walk |
| user_mode_i | input | 1 | 1 for user privilege, 0 for kernel |
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 inspect |
| fault_o | output | 1 | Protection violation for this access |
| perm_o | output | 3 | Rights for the TLB entry: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The bench sweeps every combination of privilege, access kind, flag set and the four meaningful leaf bits, filling the rest of the leaf with changing junk. A design that reads a wrong bit position, lets kernel mode honour user-only limits, or faults on the no-write flag alone would fail there. The table decoder is swept across all 32 attribute values and 32 incoming flag sets. That sweep catches swapped limit codes and a decoder that clears incoming flags instead of ORing into them. Directed checks cover the inspect kind, which must fault only on the blanket user barriers, and confirm that outputs change without any clock edge.

// File: rtl/leaf_access_guard.sv
module leaf_access_guard #(
  parameter int DESC_W       = 64,
  parameter int TBL_ATTR_LSB = 59,
  parameter int LEAF_USR_BIT = 6,
  parameter int LEAF_RO_BIT  = 7,
  parameter int LEAF_KXN_BIT = 53,
  parameter int LEAF_UXN_BIT = 54
) (
  input  logic [DESC_W-1:0] tbl_desc_i,
  input  logic [4:0]        acc_flags_i,
  output logic [4:0]        acc_flags_o,
  input  logic [DESC_W-1:0] leaf_desc_i,
  input  logic              user_mode_i,
  input  logic [1:0]        acc_kind_i,
  output logic              fault_o,
  output logic [2:0]        perm_o
);
  localparam int F_KXN  = 0;
  localparam int F_UXN  = 1;
  localparam int F_NURW = 2;
  localparam int F_NWR  = 3;
  localparam int F_NUSR = 4;
  localparam logic [1:0] K_RD = 2'd0;
  localparam logic [1:0] K_WR = 2'd1;
  localparam logic [1:0] K_FX = 2'd2;

  // table descriptor attribute decode
  logic [4:0] tbl_attr;
  logic [4:0] tbl_flags;
  assign tbl_attr = tbl_desc_i[TBL_ATTR_LSB +: 5];

  always_comb begin
    tbl_flags        = '0;
    tbl_flags[F_KXN] = tbl_attr[0];
    tbl_flags[F_UXN] = tbl_attr[1];
    case (tbl_attr[3:2])
      2'd1:    tbl_flags[F_NUSR] = 1'b1;
      2'd2:    tbl_flags[F_NWR]  = 1'b1;
      2'd3:    tbl_flags[F_NURW] = 1'b1;
      default: ;
    endcase
  end

  assign acc_flags_o = acc_flags_i | tbl_flags;

  // leaf evaluation
  logic leaf_ro, leaf_kern_only, leaf_kxn, leaf_uxn;
  logic is_rd, is_wr, is_fx;
  logic user_barred, user_rw_denied, exec_denied;

  assign leaf_ro        = leaf_desc_i[LEAF_RO_BIT];
  assign leaf_kern_only = ~leaf_desc_i[LEAF_USR_BIT];
  assign leaf_kxn       = leaf_desc_i[LEAF_KXN_BIT];
  assign leaf_uxn       = leaf_desc_i[LEAF_UXN_BIT];

  assign is_rd = (acc_kind_i == K_RD);
  assign is_wr = (acc_kind_i == K_WR);
  assign is_fx = (acc_kind_i == K_FX);

  assign user_barred    = user_mode_i & (acc_flags_i[F_NUSR] | leaf_kern_only);
  assign user_rw_denied = user_mode_i & acc_flags_i[F_NURW];
  assign exec_denied    = user_mode_i ? (acc_flags_i[F_UXN] | leaf_uxn)
                                      : (acc_flags_i[F_KXN] | leaf_kxn);

  assign fault_o = (is_wr & leaf_ro)
                 | user_barred
                 | ((is_rd | is_wr) & user_rw_denied)
                 | (is_fx & exec_denied);

  assign perm_o[0] = ~(user_barred | user_rw_denied);
  assign perm_o[1] = ~(user_barred | user_rw_denied | acc_flags_i[F_NWR] | leaf_ro);
  assign perm_o[2] = ~(user_barred | exec_denied);

  // cross-checks between the fault path and the mask path
  always_comb begin
    if (!$isunknown({tbl_desc_i, acc_flags_i, leaf_desc_i, user_mode_i, acc_kind_i})) begin
      assert_flags_keep_R1: assert ((acc_flags_o & acc_flags_i) == acc_flags_i)
        else $error("incoming restriction flag dropped");
      assert_ro_write_faults_R2: assert (!(is_wr && leaf_ro) || fault_o)
        else $error("write to read-only leaf allowed");
      assert_fetch_matches_exec_R3: assert (!is_fx || (fault_o == !perm_o[2]))
        else $error("fetch verdict disagrees with execute right");
      assert_read_matches_right_R5: assert (!is_rd || (fault_o == !perm_o[0]))
        else $error("read verdict disagrees with read right");
      assert_write_fault_no_right_R7: assert (!(is_wr && fault_o) || !perm_o[1])
        else $error("faulting write left with write right");
      assert_user_barred_empty_R9: assert (!(user_mode_i && (acc_flags_i[F_NUSR] || leaf_kern_only))
                                           || (perm_o == 3'b000 && fault_o))
        else $error("barred user access not fully denied");
    end
  end
endmodule

// File: tb/leaf_access_guard_tb.sv
module leaf_access_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] tbl_desc, leaf_desc;
  logic [4:0]  flags_in, flags_out;
  logic        user_mode;
  logic [1:0]  kind;
  logic        fault;
  logic [2:0]  perm;

  int checks = 0;
  int failures = 0;
  logic [63:0] junk = 64'h9E37_79B9_7F4A_7C15;

  leaf_access_guard dut_i (
    .tbl_desc_i (tbl_desc),
    .acc_flags_i(flags_in),
    .acc_flags_o(flags_out),
    .leaf_desc_i(leaf_desc),
    .user_mode_i(user_mode),
    .acc_kind_i (kind),
    .fault_o    (fault),
    .perm_o     (perm)
  );

  function automatic logic [63:0] next_junk(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  function automatic logic [4:0] exp_tbl(input logic [4:0] attr, input logic [4:0] fin);
    logic [4:0] r;
    r = fin;
    if (attr[0]) r = r | 5'b00001;
    if (attr[1]) r = r | 5'b00010;
    if (attr[3:2] == 2'd1) r = r | 5'b10000;
    if (attr[3:2] == 2'd2) r = r | 5'b01000;
    if (attr[3:2] == 2'd3) r = r | 5'b00100;
    return r;
  endfunction

  function automatic logic exp_fault(input logic u, input logic [1:0] k, input logic [4:0] f,
                                     input logic ro, input logic usr, input logic kx, input logic ux);
    logic v;
    v = 1'b0;
    if (k == 2'd1 && ro) v = 1'b1;
    if (!u && k == 2'd2 && (kx || f[0])) v = 1'b1;
    if (u && (f[4] || !usr)) v = 1'b1;
    if (u && (k == 2'd0 || k == 2'd1) && f[2]) v = 1'b1;
    if (u && k == 2'd2 && (ux || f[1])) v = 1'b1;
    return v;
  endfunction

  function automatic logic [2:0] exp_perm(input logic u, input logic [4:0] f,
                                          input logic ro, input logic usr, input logic kx, input logic ux);
    logic [2:0] p;
    p = 3'b111;
    if (f[3] || ro) p[1] = 1'b0;
    if (!u && (f[0] || kx)) p[2] = 1'b0;
    if (u && (f[1] || ux)) p[2] = 1'b0;
    if (u && f[2]) p[1:0] = 2'b00;
    if (u && (f[4] || !usr)) p = 3'b000;
    return p;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (user=%0b kind=%0d flags=%b leaf=%h)",
               tag, act, exp, user_mode, kind, flags_in, leaf_desc);
    end
  endtask

  function automatic logic [63:0] make_leaf(input logic [63:0] j, input logic ro, input logic usr,
                                            input logic kx, input logic ux);
    logic [63:0] d;
    d = j;
    d[7] = ro; d[6] = usr; d[53] = kx; d[54] = ux;
    return d;
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tbl_desc = '0; leaf_desc = '0; flags_in = '0; user_mode = 1'b0; kind = 2'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // all-zero start: kernel read of a plain leaf, nothing restricted
    @(negedge clk); #1;
    check("R7 idle fault", {7'd0, fault}, 8'd0);
    check("R7 idle perm", {5'd0, perm}, 8'd7);
    check("R1 idle flags", {3'd0, flags_out}, 8'd0);

    // R1: table attribute decoder sweep
    for (int a = 0; a < 32; a++) begin
      for (int fi = 0; fi < 32; fi++) begin
        @(negedge clk);
        junk = next_junk(junk);
        tbl_desc = junk;
        tbl_desc[63:59] = a[4:0];
        flags_in = fi[4:0];
        #1;
        check("R1 table flags", {3'd0, flags_out}, {3'd0, exp_tbl(a[4:0], fi[4:0])});
      end
    end

    // R2-R10: exhaustive leaf sweep
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 4; k++) begin
        for (int f = 0; f < 32; f++) begin
          for (int l = 0; l < 16; l++) begin
            logic ro, usr, kx, ux;
            string ftag;
            ro = l[0]; usr = l[1]; kx = l[2]; ux = l[3];
            @(negedge clk);
            junk = next_junk(junk);
            leaf_desc = make_leaf(junk, ro, usr, kx, ux);
            tbl_desc = next_junk(junk);
            user_mode = m[0];
            kind = k[1:0];
            flags_in = f[4:0];
            #1;
            if (k == 3) ftag = "R6 inspect fault";
            else if (m == 1 && k == 2) ftag = "R4 R5 user fetch fault";
            else if (m == 1) ftag = "R2 R4 R5 user rw fault";
            else if (k == 2) ftag = "R3 kernel fetch fault";
            else ftag = "R2 R10 kernel rw fault";
            check(ftag, {7'd0, fault},
                  {7'd0, exp_fault(m[0], k[1:0], f[4:0], ro, usr, kx, ux)});
            check(m == 1 ? "R7 R8 R9 R10 user perm" : "R7 R8 R10 kernel perm",
                  {5'd0, perm}, {5'd0, exp_perm(m[0], f[4:0], ro, usr, kx, ux)});
          end
        end
      end
    end

    // R10: no-write flag alone never faults, but trims write
    @(negedge clk);
    leaf_desc = make_leaf(64'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    flags_in = 5'b01000; kind = 2'd1; user_mode = 1'b1; #1;
    check("R10 no-write flag fault", {7'd0, fault}, 8'd0);
    check("R10 no-write flag perm", {5'd0, perm}, 8'd5);

    // R6: inspect on read-only, exec-never leaf in user mode, user allowed
    @(negedge clk);
    leaf_desc = make_leaf(64'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    flags_in = 5'b00111; kind = 2'd3; user_mode = 1'b1; #1;
    check("R6 inspect no fault", {7'd0, fault}, 8'd0);

    // R11: outputs move without a clock edge
    @(posedge clk); #2;
    kind = 2'd2; #1;
    check("R11 same-cycle fault", {7'd0, fault}, 8'd1);
    leaf_desc[6] = 1'b0; flags_in = 5'b00000; kind = 2'd0; #1;
    check("R11 same-cycle perm", {5'd0, perm}, 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule